// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit executes the eight bit-field instructions of a 64-bit processor pipeline. Each operation takes a source register value, the current destination value (used only by the insert forms), a 5-bit low field, a 5-bit high field and a 3-bit operation code. A decoder turns the two fields into a bit position, a field size and a legality verdict. A mask generator builds a low-aligned mask and a positioned mask from these, and a datapath either pulls a field down to bit 0 or merges a source field into the destination. The 32-bit forms return their 32-bit result sign-extended to 64 bits.

Results are registered. An operation issued with `issue_vld` high in one cycle appears on the outputs after the next rising clock edge. A legal operation raises `wr_en` with the result. An illegal field combination raises `rsv_trap` instead and holds `result` at zero. Register writeback, fetch and decode beyond the operation code are left to the surrounding pipeline.

Top module: `bfx_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `wr_en` and `rsv_trap` are 0 and `result` is 0 until an operation is issued.
- R2: An operation issued in one cycle is reflected on `wr_en`, `rsv_trap` and `result` after the next rising edge. In a cycle after one with `issue_vld` low, `wr_en` and `rsv_trap` are 0 and `result` is 0.
- R3: Code 0 (32-bit extract) uses position = lo and size = hi + 1, and returns source bits [pos+size-1:pos] at bit 0, sign-extended from bit 31. It is illegal when lo + hi > 31.
- R4: Code 1 (32-bit insert) uses position = lo and size = hi − lo + 1. It replaces bits hi..lo of the destination's low 32 bits with the low bits of the source and sign-extends the merged word from bit 31. It is illegal when lo > hi.
- R5: Code 2 (64-bit extract) uses position = lo and size = hi + 1, zero-extends the result, and is legal for every field pair.
- R6: Code 3 (64-bit extract, long field) uses position = lo and size = hi + 33. Source bits above bit 63 read as zero. It is illegal only when lo + hi > 63, so it is legal for every 5-bit field pair.
- R7: Code 4 (64-bit extract, upper field) uses position = lo + 32 and size = hi + 1. Source bits above bit 63 read as zero, and it is legal for every field pair.
- R8: Code 5 (64-bit insert) uses position = lo and size = hi − lo + 1. Destination bits outside the field pass unchanged. It is illegal when lo > hi.
- R9: Code 6 (64-bit insert, long field) uses position = lo and size = hi − lo + 33. Mask bits above bit 63 are dropped. It is illegal when lo > hi.
- R10: Code 7 (64-bit insert, upper field) uses position = lo + 32 and size = hi − lo + 1. It is illegal when lo > hi.
- R11: For an illegal operation, `rsv_trap` is 1, `wr_en` is 0 and `result` is 0. `wr_en` and `rsv_trap` are never high together.
- R12: A size of 64 gives an all-ones 64-bit mask, so codes 3 and 6 with lo = 0 and hi = 31 return the source unchanged. A 32-bit form with size 32 gives a full 32-bit mask, so code 0 with lo = 0 and hi = 31 returns the sign-extended low word of the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (0 to 7, see R3 to R10) |
| field_lo | input | 5 | Low field of the instruction |
| field_hi | input | 5 | High field of the instruction |
| src_val | input | 64 | Source register value |
| dst_val | input | 64 | Current destination value, used by inserts |
| wr_en | output | 1 | Registered: legal operation, write `result` |
| rsv_trap | output | 1 | Registered: illegal field combination |
| result | output | 64 | Registered result, zero unless `wr_en` |

## Verification
The assertions assume that `issue_vld`, `op_sel` and the two fields carry known values at every clock edge after reset, and that `issue_vld` stays low while reset is applied. The stimulus drives every input only on the falling edge and holds `issue_vld` low during reset. It sweeps all 1024 field pairs for each operation code with fixed, known data patterns, so the legality and sign-extension properties always see defined operands.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int FLDW  = 5;
    localparam int POSW  = $clog2(XLEN);
    localparam int SZW   = POSW + 1;
    localparam int OPW   = 3;

    typedef enum logic [OPW-1:0] {
        OP_EXT   = 3'd0,
        OP_INS   = 3'd1,
        OP_DEXT  = 3'd2,
        OP_DEXTM = 3'd3,
        OP_DEXTU = 3'd4,
        OP_DINS  = 3'd5,
        OP_DINSM = 3'd6,
        OP_DINSU = 3'd7
    } bfx_op_e;

    typedef struct packed {
        logic [POSW-1:0] pos;
        logic [SZW-1:0]  size;
        logic            legal;
        logic            narrow;
        logic            merge;
    } bfx_ctl_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [OPW-1:0]  op_sel,
    input  logic [FLDW-1:0] field_lo,
    input  logic [FLDW-1:0] field_hi,
    output bfx_ctl_t        ctl
);
    localparam logic [SZW-1:0] ONE    = SZW'(1);
    localparam logic [SZW-1:0] OFFSET = SZW'(HALF);
    localparam logic [SZW-1:0] LIM32  = SZW'(HALF - 1);
    localparam logic [SZW-1:0] LIM64  = SZW'(XLEN - 1);

    logic [SZW-1:0] lo_w;
    logic [SZW-1:0] hi_w;
    logic [SZW-1:0] span_ext;
    logic [SZW-1:0] span_ins;
    logic [SZW-1:0] sum_w;
    logic           ordered;

    assign lo_w     = SZW'(field_lo);
    assign hi_w     = SZW'(field_hi);
    assign span_ext = hi_w + ONE;
    assign span_ins = hi_w - lo_w + ONE;
    assign sum_w    = lo_w + hi_w;
    assign ordered  = (field_lo <= field_hi);

    always_comb begin
        ctl.pos    = POSW'(lo_w);
        ctl.size   = span_ext;
        ctl.legal  = 1'b1;
        ctl.narrow = 1'b0;
        ctl.merge  = 1'b0;
        unique case (bfx_op_e'(op_sel))
            OP_EXT: begin
                ctl.legal  = (sum_w <= LIM32);
                ctl.narrow = 1'b1;
            end
            OP_INS: begin
                ctl.size   = span_ins;
                ctl.legal  = ordered;
                ctl.narrow = 1'b1;
                ctl.merge  = 1'b1;
            end
            OP_DEXT: begin
                ctl.legal = (sum_w <= LIM64);
            end
            OP_DEXTM: begin
                ctl.size  = span_ext + OFFSET;
                ctl.legal = (sum_w <= LIM64);
            end
            OP_DEXTU: begin
                ctl.pos   = POSW'(lo_w + OFFSET);
                ctl.legal = (sum_w <= LIM64);
            end
            OP_DINS: begin
                ctl.size  = span_ins;
                ctl.legal = ordered;
                ctl.merge = 1'b1;
            end
            OP_DINSM: begin
                ctl.size  = span_ins + OFFSET;
                ctl.legal = ordered;
                ctl.merge = 1'b1;
            end
            OP_DINSU: begin
                ctl.pos   = POSW'(lo_w + OFFSET);
                ctl.size  = span_ins;
                ctl.legal = ordered;
                ctl.merge = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask
    import bfx_pkg::*;
(
    input  logic [POSW-1:0] pos,
    input  logic [SZW-1:0]  size,
    output logic [XLEN-1:0] low_mask,
    output logic [XLEN-1:0] field_mask
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign low_mask[i] = (SZW'(i) < size);
    end

    assign field_mask = low_mask << pos;
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
    import bfx_pkg::*;
(
    input  bfx_ctl_t        ctl,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] low_mask,
    input  logic [XLEN-1:0] field_mask,
    output logic [XLEN-1:0] value
);
    logic [XLEN-1:0] pulled;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] picked;

    assign pulled = (src_val >> ctl.pos) & low_mask;
    assign merged = (dst_val & ~field_mask) | ((src_val << ctl.pos) & field_mask);
    assign picked = ctl.merge ? merged : pulled;

    always_comb begin
        if (!ctl.legal)
            value = '0;
        else if (ctl.narrow)
            value = {{(XLEN-HALF){picked[HALF-1]}}, picked[HALF-1:0]};
        else
            value = picked;
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic [2:0]      op_sel,
    input  logic [4:0]      field_lo,
    input  logic [4:0]      field_hi,
    input  logic [63:0]     src_val,
    input  logic [63:0]     dst_val,
    output logic            wr_en,
    output logic            rsv_trap,
    output logic [63:0]     result
);
    bfx_ctl_t        ctl;
    logic [XLEN-1:0] low_mask;
    logic [XLEN-1:0] field_mask;
    logic [XLEN-1:0] value;

    bfx_decode u_dec (
        .op_sel   (op_sel),
        .field_lo (field_lo),
        .field_hi (field_hi),
        .ctl      (ctl)
    );

    bfx_mask u_msk (
        .pos        (ctl.pos),
        .size       (ctl.size),
        .low_mask   (low_mask),
        .field_mask (field_mask)
    );

    bfx_datapath u_dp (
        .ctl        (ctl),
        .src_val    (src_val),
        .dst_val    (dst_val),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .value      (value)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            rsv_trap <= 1'b0;
            result   <= '0;
        end else begin
            wr_en    <= issue_vld & ctl.legal;
            rsv_trap <= issue_vld & ~ctl.legal;
            result   <= issue_vld ? value : '0;
        end
    end

    p_one_hot_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rsv_trap));

    p_trap_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_trap |-> (result == '0));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> (!wr_en && !rsv_trap && result == '0));

    p_ins_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && op_sel inside {3'd1, 3'd5, 3'd6, 3'd7} && field_lo > field_hi)
        |=> (rsv_trap && !wr_en));

    p_dext_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && op_sel == 3'd2) |=> wr_en);

    p_narrow_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && op_sel inside {3'd0, 3'd1})
        |=> (result[63:32] == {32{result[31]}}));
endmodule

// File: tb/sim_bfx_unit.sv
module sim_bfx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [4:0]  field_lo = '0;
    logic [4:0]  field_hi = '0;
    logic [63:0] src_val = '0;
    logic [63:0] dst_val = '0;
    logic        wr_en;
    logic        rsv_trap;
    logic [63:0] result;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bfx_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .op_sel(op_sel),
        .field_lo(field_lo), .field_hi(field_hi), .src_val(src_val),
        .dst_val(dst_val), .wr_en(wr_en), .rsv_trap(rsv_trap), .result(result)
    );

    function automatic void model(input int op, input int lo, input int hi,
                                  input logic [63:0] s, input logic [63:0] d,
                                  output bit legal, output logic [63:0] v);
        int  pos;
        int  size;
        bit  narrow;
        bit  merge;
        pos = lo; size = hi + 1; narrow = 0; merge = 0; legal = 1;
        case (op)
            0: begin legal = (lo + hi <= 31); narrow = 1; end
            1: begin size = hi - lo + 1; legal = (lo <= hi); narrow = 1; merge = 1; end
            2: legal = (lo + hi <= 63);
            3: begin size = hi + 33; legal = (lo + hi <= 63); end
            4: begin pos = lo + 32; legal = (lo + hi <= 63); end
            5: begin size = hi - lo + 1; legal = (lo <= hi); merge = 1; end
            6: begin size = hi - lo + 33; legal = (lo <= hi); merge = 1; end
            default: begin pos = lo + 32; size = hi - lo + 1; legal = (lo <= hi); merge = 1; end
        endcase
        v = merge ? d : 64'd0;
        for (int i = 0; i < 64; i++) begin
            if (i < size && pos + i < 64) begin
                if (merge) v[pos + i] = s[i];
                else       v[i] = s[pos + i];
            end
        end
        if (narrow) v = {{32{v[31]}}, v[31:0]};
        if (!legal) v = 64'd0;
    endfunction

    task automatic check(input string tag, input logic exp_w, input logic exp_t,
                         input logic [63:0] exp_v);
        n_vec++;
        if (wr_en !== exp_w || rsv_trap !== exp_t || result !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got wr_en=%b trap=%b result=%h, expected wr_en=%b trap=%b result=%h",
                     tag, wr_en, rsv_trap, result, exp_w, exp_t, exp_v);
        end
    endtask

    task automatic apply(input string tag, input int op, input int lo, input int hi,
                         input logic [63:0] s, input logic [63:0] d);
        bit          legal;
        logic [63:0] v;
        @(negedge clk);
        issue_vld = 1'b1; op_sel = 3'(op);
        field_lo = 5'(lo); field_hi = 5'(hi);
        src_val = s; dst_val = d;
        model(op, lo, hi, s, d, legal, v);
        @(negedge clk);
        check(tag, legal, !legal, v);
    endtask

    task automatic sweep(input string tag, input int op);
        for (int lo = 0; lo < 32; lo++)
            for (int hi = 0; hi < 32; hi++) begin
                apply(tag, op, lo, hi, 64'h8F3C_A5E1_7B24_D96E, 64'h1234_5678_9ABC_DEF0);
                apply(tag, op, lo, hi, 64'h70C3_5A1E_84DB_2691, 64'hEDCB_A987_6543_210F);
            end
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, 1'b0, 64'd0);
    endtask

    task automatic t_idle_r2();
        apply("R2 issue", 5, 3, 20, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        issue_vld = 1'b0;
        @(negedge clk);
        check("R2 idle after issue", 1'b0, 1'b0, 64'd0);
    endtask

    task automatic t_ext32_r3();   sweep("R3 ext32", 0);     endtask
    task automatic t_ins32_r4();   sweep("R4 ins32", 1);     endtask
    task automatic t_dext_r5();    sweep("R5 dext", 2);      endtask
    task automatic t_dextm_r6();   sweep("R6 dext long", 3); endtask
    task automatic t_dextu_r7();   sweep("R7 dext upper", 4); endtask
    task automatic t_dins_r8();    sweep("R8 dins", 5);      endtask
    task automatic t_dinsm_r9();   sweep("R9 dins long", 6); endtask
    task automatic t_dinsu_r10();  sweep("R10 dins upper", 7); endtask

    task automatic t_trap_r11();
        apply("R11 ext32 illegal", 0, 20, 20, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        check("R11 ext32 trap", 1'b0, 1'b1, 64'd0);
        apply("R11 dins illegal", 5, 9, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R11 dins trap", 1'b0, 1'b1, 64'd0);
    endtask

    task automatic t_fullwidth_r12();
        logic [63:0] s;
        s = 64'hA5A5_0F0F_C3C3_9696;
        apply("R12 long extract", 3, 0, 31, s, 64'd0);
        check("R12 long extract identity", 1'b1, 1'b0, s);
        apply("R12 long insert", 6, 0, 31, s, 64'h1111_2222_3333_4444);
        check("R12 long insert identity", 1'b1, 1'b0, s);
        apply("R12 ext32 full", 0, 0, 31, s, 64'd0);
        check("R12 ext32 full word", 1'b1, 1'b0, 64'hFFFF_FFFF_C3C3_9696);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected run to finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_r1();
        t_idle_r2();
        t_ext32_r3();
        t_ins32_r4();
        t_dext_r5();
        t_dextm_r6();
        t_dextu_r7();
        t_dins_r8();
        t_dinsm_r9();
        t_dinsu_r10();
        t_trap_r11();
        t_fullwidth_r12();
        t_idle_r2();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule